// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that a small 8-bit processor core uses to take an interrupt and to come back from one. It owns the 16-bit program counter, the stack pointer and the global interrupt enable. It watches a vector of pending request flags. When the core signals that an instruction has just finished and interrupts are enabled, the sequencer accepts the lowest-numbered pending request. It then holds the core for four cycles. In those cycles it writes the two program counter bytes to a byte-wide stack memory, lowers the stack pointer by two, clears the global enable and loads the handler address. The handler address is computed from a base input and the request index.

On a return request from the core's decoder, the sequencer again holds the core for four cycles. It reads the two bytes back from the stack with pre-increment addressing, raises the stack pointer by two, restores the program counter and sets the global enable. The end of a return sequence is never used as an acceptance point. A request that is still pending therefore waits until one instruction of the interrupted program has completed. Outside the sequences, the core updates the program counter, stack pointer and enable through dedicated write inputs.

States: `SQ_RUN` (core runs), `SQ_PUSH_LO`, `SQ_PUSH_HI`, `SQ_LOAD_VEC` and `SQ_ENTRY_FETCH` (entry), `SQ_POP_HI`, `SQ_POP_LO`, `SQ_LOAD_RET` and `SQ_RET_FETCH` (return). The transitions are as follows. `SQ_RUN` goes to `SQ_POP_HI` on `reti_go`. Otherwise it goes to `SQ_PUSH_LO` on an accepted request. Each sequence state advances unconditionally to the next one. Both fetch states return to `SQ_RUN`.

Top module: `irq_seq`

## Requirements
- R1: After reset, `hold`, `gie`, `irq_ack`, `stk_wr` and `stk_rd` are 0, `pc` equals RESET_PC (0) and `sp` equals SP_RESET (0x00FF).
- R2: A request is accepted only at a clock edge where the sequencer is in the run state, `insn_done` is 1, `gie` is 1 and `reti_go` is 0. While a multi-cycle instruction keeps `insn_done` low, no request is accepted.
- R3: Among pending requests, the lowest bit index wins. `irq_ack` is 1 for exactly one cycle, the cycle after acceptance, and `irq_ack_idx` carries the winning index.
- R4: In the first entry cycle, the low PC byte is written at address `sp`. In the second entry cycle, the high PC byte is written at `sp`-1. The stack pointer ends two lower.
- R5: Entry holds the core for exactly four cycles. When `hold` falls, `pc` equals `vec_base` + index × VEC_STRIDE (default 2) and `gie` is 0.
- R6: A `reti_go` in the run state holds the core for exactly four cycles. The sequencer reads at `sp`+1 and then at the next address, with read data arriving one cycle after `stk_rd`. It restores `pc` as {first byte, second byte}, raises `sp` by 2 and sets `gie`.
- R7: After a return, a pending enabled request is not accepted until `insn_done` has been seen once in the run state.
- R8: Requests that appear while `hold` is 1 produce no acknowledge during the sequence and stay pending for the next allowed boundary.
- R9: Core writes to PC, SP and enable (`core_pc_we`, `core_sp_we`, `ie_set`, `ie_clr`) take effect one edge later in the run state and are ignored while `hold` is 1.
- R10: When `reti_go` and an acceptable request coincide, the return sequence starts and no acknowledge is given.
- R11: With `gie` at 0, pending requests are never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Pending request flags, bit 0 highest priority |
| irq_ack | output | 1 | One-cycle acknowledge in the first entry cycle |
| irq_ack_idx | output | IDXW | Index of the request being serviced |
| vec_base | input | 16 | Handler table base address |
| insn_done | input | 1 | Current instruction completes this cycle |
| reti_go | input | 1 | Decoded return-from-interrupt |
| ie_set | input | 1 | Core sets the global enable |
| ie_clr | input | 1 | Core clears the global enable |
| core_pc_we | input | 1 | Core program counter write |
| core_pc_wd | input | 16 | Core program counter value |
| core_sp_we | input | 1 | Core stack pointer write |
| core_sp_wd | input | SPW | Core stack pointer value |
| stk_addr | output | SPW | Stack memory address |
| stk_wr | output | 1 | Stack write strobe |
| stk_rd | output | 1 | Stack read strobe (data next cycle) |
| stk_wdata | output | 8 | Stack write data |
| stk_rdata | input | 8 | Stack read data |
| pc | output | 16 | Program counter |
| sp | output | SPW | Stack pointer |
| gie | output | 1 | Global interrupt enable |
| hold | output | 1 | Core stall during a sequence |

## Verification
The assertions check several properties on every cycle. Each acknowledge must follow an allowed boundary and name a request that was pending. The push order, addresses and data must be correct. Entry must last exactly four cycles, with the enable cleared and the stack pointer two lower. A return must read at `sp`+1, end with the stack pointer raised by two and the enable set, and take priority over a coincident request. The bench scenarios show what a single-cycle property cannot. These are the priority choice among several requests, the handler address, the byte round trip through a modelled stack memory, delay under a long instruction, the one-instruction rule after a return, and core writes being ignored during a sequence.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

    localparam int PC_W = 16;

    typedef enum logic [3:0] {
        SQ_RUN,
        SQ_PUSH_LO,
        SQ_PUSH_HI,
        SQ_LOAD_VEC,
        SQ_ENTRY_FETCH,
        SQ_POP_HI,
        SQ_POP_LO,
        SQ_LOAD_RET,
        SQ_RET_FETCH
    } seq_state_e;

    typedef struct packed {
        logic hold;
        logic push_lo;
        logic push_hi;
        logic ld_vec;
        logic pop_rd;
        logic cap_hi;
        logic ld_ret;
    } seq_ctl_t;

endpackage

// File: rtl/irqseq_pick.sv
module irqseq_pick #(
    parameter int NSRC = 8,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] req,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
    import irqseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       insn_done,
    input  logic       reti_go,
    input  logic       gie,
    input  logic       any_req,
    output logic       accept,
    output logic       ack,
    output seq_ctl_t   ctl
);
    seq_state_e state_q, state_d;

    // Acceptance is only possible from the run state; a return wins.
    assign accept = (state_q == SQ_RUN) && !reti_go && insn_done && gie && any_req;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_RUN: begin
                if (reti_go)     state_d = SQ_POP_HI;
                else if (accept) state_d = SQ_PUSH_LO;
            end
            SQ_PUSH_LO:     state_d = SQ_PUSH_HI;
            SQ_PUSH_HI:     state_d = SQ_LOAD_VEC;
            SQ_LOAD_VEC:    state_d = SQ_ENTRY_FETCH;
            SQ_ENTRY_FETCH: state_d = SQ_RUN;
            SQ_POP_HI:      state_d = SQ_POP_LO;
            SQ_POP_LO:      state_d = SQ_LOAD_RET;
            SQ_LOAD_RET:    state_d = SQ_RET_FETCH;
            // The end of a return is not an acceptance point.
            SQ_RET_FETCH:   state_d = SQ_RUN;
            default:        state_d = SQ_RUN;
        endcase
    end

    always_comb begin
        ctl      = '0;
        ack      = 1'b0;
        ctl.hold = (state_q != SQ_RUN);
        unique case (state_q)
            SQ_PUSH_LO: begin
                ctl.push_lo = 1'b1;
                ack         = 1'b1;
            end
            SQ_PUSH_HI:  ctl.push_hi = 1'b1;
            SQ_LOAD_VEC: ctl.ld_vec  = 1'b1;
            SQ_POP_HI:   ctl.pop_rd  = 1'b1;
            SQ_POP_LO: begin
                ctl.pop_rd = 1'b1;
                ctl.cap_hi = 1'b1;
            end
            SQ_LOAD_RET: ctl.ld_ret = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/irqseq_regs.sv
module irqseq_regs
    import irqseq_pkg::*;
#(
    parameter int          NSRC       = 8,
    parameter int          IDXW       = $clog2(NSRC),
    parameter int          SPW        = 16,
    parameter int          VEC_STRIDE = 2,
    parameter logic [15:0] RESET_PC   = 16'h0000,
    parameter logic [SPW-1:0] SP_RESET = SPW'(16'h00FF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_ctl_t         ctl,
    input  logic             accept,
    input  logic [IDXW-1:0]  pick_idx,
    input  logic [PC_W-1:0]  vec_base,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             core_pc_we,
    input  logic [PC_W-1:0]  core_pc_wd,
    input  logic             core_sp_we,
    input  logic [SPW-1:0]   core_sp_wd,
    input  logic [7:0]       stk_rdata,
    output logic [PC_W-1:0]  pc,
    output logic [SPW-1:0]   sp,
    output logic             gie,
    output logic [IDXW-1:0]  idx_q,
    output logic [SPW-1:0]   stk_addr,
    output logic [7:0]       stk_wdata,
    output logic             stk_wr,
    output logic             stk_rd
);
    logic [7:0]      hi_q;
    logic [PC_W-1:0] vec_addr;

    assign vec_addr  = vec_base + PC_W'(idx_q) * PC_W'(VEC_STRIDE);
    assign stk_wr    = ctl.push_lo | ctl.push_hi;
    assign stk_rd    = ctl.pop_rd;
    assign stk_addr  = ctl.pop_rd ? sp + SPW'(1) : sp;
    assign stk_wdata = ctl.push_hi ? pc[15:8] : pc[7:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= RESET_PC;
            sp    <= SP_RESET;
            gie   <= 1'b0;
            hi_q  <= '0;
            idx_q <= '0;
        end else begin
            if (ctl.hold) begin
                if (stk_wr)     sp   <= sp - SPW'(1);
                if (ctl.pop_rd) sp   <= sp + SPW'(1);
                if (ctl.cap_hi) hi_q <= stk_rdata;
                if (ctl.ld_vec) pc   <= vec_addr;
                if (ctl.ld_ret) pc   <= {hi_q, stk_rdata};
                if (ctl.push_lo) gie <= 1'b0;
                if (ctl.ld_ret)  gie <= 1'b1;
            end else begin
                if (core_pc_we) pc <= core_pc_wd;
                if (core_sp_we) sp <= core_sp_wd;
                if (ie_clr)      gie <= 1'b0;
                else if (ie_set) gie <= 1'b1;
            end
            if (accept) idx_q <= pick_idx;
        end
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irqseq_pkg::*;
#(
    parameter int          NSRC       = 8,
    parameter int          IDXW       = $clog2(NSRC),
    parameter int          SPW        = 16,
    parameter int          VEC_STRIDE = 2,
    parameter logic [15:0] RESET_PC   = 16'h0000,
    parameter logic [SPW-1:0] SP_RESET = SPW'(16'h00FF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req,
    output logic            irq_ack,
    output logic [IDXW-1:0] irq_ack_idx,
    input  logic [15:0]     vec_base,
    input  logic            insn_done,
    input  logic            reti_go,
    input  logic            ie_set,
    input  logic            ie_clr,
    input  logic            core_pc_we,
    input  logic [15:0]     core_pc_wd,
    input  logic            core_sp_we,
    input  logic [SPW-1:0]  core_sp_wd,
    output logic [SPW-1:0]  stk_addr,
    output logic            stk_wr,
    output logic            stk_rd,
    output logic [7:0]      stk_wdata,
    input  logic [7:0]      stk_rdata,
    output logic [15:0]     pc,
    output logic [SPW-1:0]  sp,
    output logic            gie,
    output logic            hold
);
    logic            any_req;
    logic [IDXW-1:0] pick_idx;
    logic            accept;
    seq_ctl_t        ctl;

    irqseq_pick #(.NSRC(NSRC), .IDXW(IDXW)) u_pick (
        .req (irq_req),
        .any (any_req),
        .idx (pick_idx)
    );

    irqseq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .reti_go   (reti_go),
        .gie       (gie),
        .any_req   (any_req),
        .accept    (accept),
        .ack       (irq_ack),
        .ctl       (ctl)
    );

    irqseq_regs #(
        .NSRC(NSRC), .IDXW(IDXW), .SPW(SPW), .VEC_STRIDE(VEC_STRIDE),
        .RESET_PC(RESET_PC), .SP_RESET(SP_RESET)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .accept     (accept),
        .pick_idx   (pick_idx),
        .vec_base   (vec_base),
        .ie_set     (ie_set),
        .ie_clr     (ie_clr),
        .core_pc_we (core_pc_we),
        .core_pc_wd (core_pc_wd),
        .core_sp_we (core_sp_we),
        .core_sp_wd (core_sp_wd),
        .stk_rdata  (stk_rdata),
        .pc         (pc),
        .sp         (sp),
        .gie        (gie),
        .idx_q      (irq_ack_idx),
        .stk_addr   (stk_addr),
        .stk_wdata  (stk_wdata),
        .stk_wr     (stk_wr),
        .stk_rd     (stk_rd)
    );

    assign hold = ctl.hold;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int NSRC = 8,
    parameter int IDXW = $clog2(NSRC),
    parameter int SPW  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] irq_req,
    input logic            irq_ack,
    input logic [IDXW-1:0] irq_ack_idx,
    input logic            insn_done,
    input logic            reti_go,
    input logic [SPW-1:0]  stk_addr,
    input logic            stk_wr,
    input logic            stk_rd,
    input logic [7:0]      stk_wdata,
    input logic [15:0]     pc,
    input logic [SPW-1:0]  sp,
    input logic            gie,
    input logic            hold
);
    // R2: acknowledge only follows an allowed instruction boundary
    a_r2_ack_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(insn_done && !hold && gie && !reti_go));

    // R3: the acknowledged index was pending; pulse lasts one cycle
    a_r3_idx_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ((($past(irq_req) >> irq_ack_idx) & NSRC'(1)) != '0));
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R4: low byte at sp, then high byte one below
    a_r4_push_low: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (stk_wr && stk_addr == sp && stk_wdata == pc[7:0]));
    a_r4_push_high: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (stk_wr && stk_addr == $past(sp) - SPW'(1) && stk_wdata == $past(pc[15:8])));

    // R5: four held cycles, enable cleared, stack pointer two lower
    a_r5_entry_len: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> hold ##1 hold ##1 hold ##1 hold ##1 !hold);
    a_r5_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !gie);
    a_r5_sp_drop: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> ##1 (sp == $past(sp, 2) - SPW'(2)));

    // R6: pop starts at sp+1, ends two higher with enable set
    a_r6_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_rd) |-> (stk_addr == sp + SPW'(1)));
    a_r6_ret_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_rd) |=> ##2 (sp == $past(sp, 3) + SPW'(2) && gie));

    // R10: a return in the run state wins over any request
    a_r10_ret_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_go && !hold) |=> (stk_rd && !irq_ack));
endmodule

bind irq_seq irq_seq_chk #(.NSRC(NSRC), .IDXW(IDXW), .SPW(SPW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_ack_idx(irq_ack_idx), .insn_done(insn_done), .reti_go(reti_go),
    .stk_addr(stk_addr), .stk_wr(stk_wr), .stk_rd(stk_rd),
    .stk_wdata(stk_wdata), .pc(pc), .sp(sp), .gie(gie), .hold(hold)
);

// File: tb/test_irq_seq.sv
module test_irq_seq;
    localparam int NSRC = 8;
    localparam int IDXW = 3;
    localparam int SPW  = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] irq_req;
    logic            irq_ack;
    logic [IDXW-1:0] irq_ack_idx;
    logic [15:0]     vec_base;
    logic            insn_done, reti_go, ie_set, ie_clr;
    logic            core_pc_we, core_sp_we;
    logic [15:0]     core_pc_wd;
    logic [SPW-1:0]  core_sp_wd;
    logic [SPW-1:0]  stk_addr;
    logic            stk_wr, stk_rd;
    logic [7:0]      stk_wdata;
    logic [7:0]      stk_rdata;
    logic [15:0]     pc;
    logic [SPW-1:0]  sp;
    logic            gie, hold;

    int n_checks = 0;
    int n_err    = 0;
    logic [7:0] mem [0:255];

    always #2 clk = ~clk;

    irq_seq i_irq_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
        .irq_ack_idx(irq_ack_idx), .vec_base(vec_base), .insn_done(insn_done),
        .reti_go(reti_go), .ie_set(ie_set), .ie_clr(ie_clr),
        .core_pc_we(core_pc_we), .core_pc_wd(core_pc_wd),
        .core_sp_we(core_sp_we), .core_sp_wd(core_sp_wd),
        .stk_addr(stk_addr), .stk_wr(stk_wr), .stk_rd(stk_rd),
        .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
        .pc(pc), .sp(sp), .gie(gie), .hold(hold)
    );

    // Byte-wide stack memory with one-cycle read latency
    always @(posedge clk) begin
        if (stk_wr) mem[stk_addr[7:0]] <= stk_wdata;
        if (stk_rd) stk_rdata <= mem[stk_addr[7:0]];
    end

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Counts held cycles starting at the current negedge; also counts acks seen
    task automatic count_hold(output int n, output int acks);
        n = 0;
        acks = 0;
        while (hold && n < 12) begin
            n++;
            if (irq_ack) acks++;
            cyc();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        check("R1", "hold", hold, 0);
        check("R1", "gie", gie, 0);
        check("R1", "pc", pc, 16'h0000);
        check("R1", "sp", sp, 16'h00FF);
        check("R1", "strobes", {irq_ack, stk_wr, stk_rd}, 0);
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic t_setup();
        core_pc_we = 1; core_pc_wd = 16'h1234;
        core_sp_we = 1; core_sp_wd = 16'h0080;
        ie_set = 1;
        cyc();
        core_pc_we = 0; core_sp_we = 0; ie_set = 0;
        check("R9", "core pc write", pc, 16'h1234);
        check("R9", "core sp write", sp, 16'h0080);
        check("R9", "ie_set", gie, 1);
    endtask

    task automatic t_masked();
        int acks = 0;
        ie_clr = 1; cyc(); ie_clr = 0;
        irq_req = 8'h04; insn_done = 1;
        repeat (3) begin cyc(); acks += int'(irq_ack) + int'(hold); end
        insn_done = 0; irq_req = '0;
        check("R11", "ack/hold with gie=0", acks, 0);
        ie_set = 1; cyc(); ie_set = 0;
        check("R11", "gie restored", gie, 1);
    endtask

    task automatic t_entry_basic();
        int n, acks;
        vec_base = 16'h0100;
        irq_req = 8'b0010_1000;
        insn_done = 1;
        cyc();
        insn_done = 0;
        check("R3", "ack", irq_ack, 1);
        check("R3", "ack index", irq_ack_idx, 3);
        irq_req = '0;
        count_hold(n, acks);
        check("R5", "entry hold cycles", n, 4);
        check("R3", "ack pulses", acks, 1);
        check("R5", "vector pc", pc, 16'h0106);
        check("R5", "gie cleared", gie, 0);
        check("R4", "sp after push", sp, 16'h007E);
        check("R4", "low byte at sp", mem[8'h80], 8'h34);
        check("R4", "high byte at sp-1", mem[8'h7F], 8'h12);
    endtask

    task automatic t_return();
        int n, acks;
        reti_go = 1;
        cyc();
        reti_go = 0;
        check("R6", "first pop address", stk_addr, 16'h007F);
        check("R6", "read strobe", stk_rd, 1);
        count_hold(n, acks);
        check("R6", "return hold cycles", n, 4);
        check("R6", "restored pc", pc, 16'h1234);
        check("R6", "sp after pop", sp, 16'h0080);
        check("R6", "gie set", gie, 1);
    endtask

    task automatic t_multicycle();
        int acks = 0;
        int n, a2;
        irq_req = 8'h01;
        insn_done = 0;
        repeat (3) begin cyc(); acks += int'(irq_ack); end
        check("R2", "no ack mid-instruction", acks, 0);
        insn_done = 1;
        cyc();
        insn_done = 0;
        check("R2", "ack at boundary", irq_ack, 1);
        check("R3", "index 0", irq_ack_idx, 0);
        irq_req = '0;
        count_hold(n, a2);
        check("R2", "vector pc", pc, 16'h0100);
    endtask

    task automatic t_ret_then_one();
        int n, acks;
        int early = 0;
        ie_set = 1; cyc(); ie_set = 0;
        irq_req = 8'h02;
        reti_go = 1; insn_done = 1;
        cyc();
        reti_go = 0;
        check("R10", "no ack with return", irq_ack, 0);
        check("R10", "return started", stk_rd, 1);
        count_hold(n, acks);
        check("R8", "no ack during return", acks, 0);
        check("R6", "restored pc", pc, 16'h1234);
        insn_done = 0;
        repeat (2) begin cyc(); early += int'(irq_ack) + int'(hold); end
        check("R7", "no ack before one instruction", early, 0);
        insn_done = 1;
        cyc();
        insn_done = 0;
        check("R7", "ack after one instruction", irq_ack, 1);
        check("R8", "pending index kept", irq_ack_idx, 1);
        irq_req = '0;
        // R9: core writes during the held entry are ignored
        core_pc_we = 1; core_pc_wd = 16'hBEEF;
        core_sp_we = 1; core_sp_wd = 16'h0011;
        ie_set = 1;
        count_hold(n, acks);
        core_pc_we = 0; core_sp_we = 0; ie_set = 0;
        check("R9", "pc not overwritten", pc, 16'h0102);
        check("R9", "sp not overwritten", sp, 16'h007E);
        check("R9", "gie not set", gie, 0);
    endtask

    initial begin
        rst_n = 0; irq_req = '0; vec_base = '0; insn_done = 0; reti_go = 0;
        ie_set = 0; ie_clr = 0; core_pc_we = 0; core_sp_we = 0;
        core_pc_wd = '0; core_sp_wd = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        cyc();
        t_reset();
        t_setup();
        t_masked();
        t_entry_basic();
        t_return();
        t_multicycle();
        t_ret_then_one();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule